// File: doc/BRIEF.md
# NAND Page Chunk Hamming Parity Generator

This block builds a 24-bit Hamming-style check code over one 512-byte chunk of NAND page data while the data moves past on an 8-bit or 16-bit bus. Every data bit in the chunk has a 12-bit position: a 9-bit byte index above a 3-bit bit index. For each of the 12 position bits the block keeps two running parities. The odd parity covers the data bits whose position bit is 1. The even parity covers the data bits whose position bit is 0. The parity is not inverted, so a chunk that reads back as erased (all 0xFF) gives a code of zero.

Software or a flash sequencer pulses `arm` at the start of a chunk. The block then takes one beat per `din_vld` until it has seen 512 bytes, raises `done`, and holds the packed 32-bit code on `result` until the next `arm`. A `halt` pulse stops a chunk part way through and keeps the partial code.

Top module: `nand_hecc_gen`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0. Data beats are ignored until the first `arm`.
- R2: An `arm` pulse zeroes `result`, clears `done`, resets the byte position to 0 and starts a chunk. It wins over `halt`, and a beat presented in the same cycle is not counted.
- R3: For each position bit k (0..11), the odd parity is the XOR of all data bits whose position bit k is 1, and the even parity is the XOR of all data bits whose position bit k is 0. The position is {byte index[8:0], bit index[2:0]}. There is no inversion: an all-0xFF chunk and an all-0x00 chunk both give 0.
- R4: `result[27:16]` holds the 12 odd parities and `result[11:0]` holds the 12 even parities, with position bit k at offset k in each group. Bits 31:28 and 15:12 are always 0.
- R5: In 8-bit mode (`bus16`=0 at arm), each accepted beat is one byte taken from `din[7:0]`, and 512 beats complete a chunk. `din[15:8]` is ignored.
- R6: In 16-bit mode (`bus16`=1 at arm), each accepted beat is two bytes: `din[7:0]` at byte index n and `din[15:8]` at n+1. 256 beats complete a chunk.
- R7: `done` rises in the cycle after the beat that brings the chunk to 512 bytes, together with the final `result`. After that, beats leave `result` and `done` unchanged until the next `arm`.
- R8: A `halt` pulse during a chunk stops accumulation. The beat in that cycle and all later beats are ignored, and `result` keeps the partial code until the next `arm`. `done` stays 0.
- R9: The bus width is captured at `arm`. A change of `bus16` during a chunk has no effect.
- R10: `result` reflects each accepted beat one clock after that beat is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Clear the code and start a new chunk |
| halt | input | 1 | Stop the chunk in progress |
| bus16 | input | 1 | Width select captured at arm: 0 = 8-bit, 1 = 16-bit |
| din_vld | input | 1 | Data beat strobe |
| din | input | 16 | Beat data, low byte first |
| result | output | 32 | Packed code: odd parities in 27:16, even parities in 11:0 |
| done | output | 1 | Chunk of 512 bytes complete |

## Verification
The embedded properties assume that `arm`, `halt` and `din_vld` are known 0/1 values after reset and that `arm` is a single-cycle pulse. The freeze properties assume nothing else writes the code while the engine is idle or finished. The stimulus changes every input only on the falling clock edge, holds reset from time zero, and never leaves a control input undriven. It pulses `arm` and `halt` for exactly one cycle each, so the properties can attach each code change to one accepted beat or one arm.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

    localparam int CHUNK_BYTES = 512;
    localparam int BYTE_W      = 8;
    localparam int BIT_IDX_W   = $clog2(BYTE_W);
    localparam int BADDR_W     = $clog2(CHUNK_BYTES);
    localparam int PADDR_W     = BADDR_W + BIT_IDX_W;
    localparam int CNT_W       = BADDR_W + 1;
    localparam int RES_W       = 32;
    localparam int HALF_W      = RES_W / 2;
    localparam int MAX_LANES   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic [PADDR_W-1:0] odd;
        logic [PADDR_W-1:0] even;
    } par_t;

    // Each set data bit toggles the odd parity of every position bit that is 1
    // and the even parity of every position bit that is 0.
    function automatic par_t byte_contrib(input logic [BADDR_W-1:0] baddr,
                                          input logic [BYTE_W-1:0]  data);
        par_t               acc;
        logic [PADDR_W-1:0] pos;
        acc = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            pos = {baddr, BIT_IDX_W'(i)};
            if (data[i]) begin
                acc.odd  = acc.odd ^ pos;
                acc.even = acc.even ^ ~pos;
            end
        end
        return acc;
    endfunction

    function automatic logic [RES_W-1:0] pack_code(input par_t p);
        logic [RES_W-1:0] w;
        w = '0;
        w[PADDR_W-1:0]               = p.even;
        w[HALF_W +: PADDR_W]         = p.odd;
        return w;
    endfunction

endpackage

// File: rtl/hecc_ctrl.sv
module hecc_ctrl
    import nand_hecc_pkg::*;
#(
    parameter int CHUNK = CHUNK_BYTES,
    parameter int AW    = BADDR_W,
    parameter int CW    = CNT_W,
    parameter int LANES = MAX_LANES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          halt,
    input  logic          bus16,
    input  logic          din_vld,
    output logic [LANES-1:0] lane_en,
    output logic [AW-1:0] base_addr,
    output logic          take,
    output logic          active,
    output logic          done
);

    eng_state_t    state;
    logic          wide;
    logic [CW-1:0] cnt;
    logic [CW-1:0] step;
    logic [CW-1:0] cnt_nxt;

    assign step    = wide ? CW'(2) : CW'(1);
    assign cnt_nxt = cnt + step;
    assign active  = (state == ST_RUN);
    assign done    = (state == ST_DONE);
    assign take    = active && din_vld && !arm && !halt;
    assign base_addr = cnt[AW-1:0];

    always_comb begin
        lane_en    = '0;
        lane_en[0] = take;
        if (LANES > 1) lane_en[LANES-1] = take && wide;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wide  <= 1'b0;
        end else if (arm) begin
            state <= ST_RUN;
            cnt   <= '0;
            wide  <= bus16;
        end else if (state == ST_RUN) begin
            if (halt) begin
                state <= ST_IDLE;
            end else if (din_vld) begin
                cnt <= cnt_nxt;
                if (cnt_nxt == CW'(CHUNK)) state <= ST_DONE;
            end
        end
    end

    // R5 / R6: a running chunk never sits at or beyond the chunk length
    assert_run_bound_R5: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < CW'(CHUNK)));

    // R9: captured width only changes on arm
    assert_width_held_R9: assert property (@(posedge clk) disable iff (rst)
        !arm |=> $stable(wide));

endmodule

// File: rtl/hecc_lane.sv
module hecc_lane
    import nand_hecc_pkg::*;
#(
    parameter int LANE = 0,
    parameter int AW   = BADDR_W,
    parameter int DW   = BYTE_W
) (
    input  logic          en,
    input  logic [AW-1:0] base_addr,
    input  logic [DW-1:0] data,
    output par_t          contrib
);

    logic [AW-1:0] addr;

    assign addr    = base_addr + AW'(LANE);
    assign contrib = en ? byte_contrib(addr, data) : '0;

endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
    import nand_hecc_pkg::*;
#(
    parameter int RW = RES_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          take,
    input  par_t          contrib,
    output logic [RW-1:0] result
);

    par_t acc;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (take) begin
            acc <= acc ^ contrib;
        end
    end

    assign result = pack_code(acc);

    // R10: without an accepted beat or a clear the code does not move
    assert_no_beat_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> $stable(result));

endmodule

// File: rtl/nand_hecc_gen.sv
module nand_hecc_gen
    import nand_hecc_pkg::*;
#(
    parameter int LANES = MAX_LANES,
    parameter int DIN_W = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             halt,
    input  logic             bus16,
    input  logic             din_vld,
    input  logic [DIN_W-1:0] din,
    output logic [RES_W-1:0] result,
    output logic             done
);

    logic [LANES-1:0]   lane_en;
    logic [BADDR_W-1:0] base_addr;
    logic               take;
    logic               active;
    par_t               lane_par [LANES];
    par_t               sum_par;

    hecc_ctrl #(
        .CHUNK (CHUNK_BYTES),
        .AW    (BADDR_W),
        .CW    (CNT_W),
        .LANES (LANES)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .halt      (halt),
        .bus16     (bus16),
        .din_vld   (din_vld),
        .lane_en   (lane_en),
        .base_addr (base_addr),
        .take      (take),
        .active    (active),
        .done      (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hecc_lane #(
            .LANE (g),
            .AW   (BADDR_W),
            .DW   (BYTE_W)
        ) lane_i (
            .en        (lane_en[g]),
            .base_addr (base_addr),
            .data      (din[g*BYTE_W +: BYTE_W]),
            .contrib   (lane_par[g])
        );
    end

    always_comb begin
        sum_par = '0;
        for (int i = 0; i < LANES; i++) sum_par = sum_par ^ lane_par[i];
    end

    hecc_accum #(
        .RW (RES_W)
    ) accum_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (arm),
        .take    (take),
        .contrib (sum_par),
        .result  (result)
    );

    // R2: arm leaves a zero code and no done flag one cycle later
    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (rst)
        arm |=> (result == '0) && !done);

    // R7: a finished chunk stays finished and frozen until re-armed
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> done && $stable(result));

    // R8: halt without arm freezes the code and leaves the engine idle
    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (halt && !arm && !done) |=> $stable(result) && !active && !done);

    // R1: an idle engine ignores beats
    assert_idle_ignore_R1: assert property (@(posedge clk) disable iff (rst)
        (!active && !arm) |=> $stable(result));

    // R4: unused bits of the packed word stay low
    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (result[RES_W-1:HALF_W+PADDR_W] == '0) && (result[HALF_W-1:PADDR_W] == '0));

endmodule

// File: tb/nand_hecc_gen_tb_top.sv
module nand_hecc_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic        w16;
        logic [1:0]  kind;
        logic [15:0] param;
        logic        use_lit;
        logic [31:0] lit;
    } vec_t;

    // kind 0: fill byte param[7:0]; kind 1: one set bit, param = {bit[11:9], byte[8:0]};
    // kind 2: mixed content seeded by param[7:0]
    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 16'h00FF, 1'b1, 32'h0000_0000},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 32'h0000_0000},
        '{1'b1, 2'd0, 16'h00FF, 1'b1, 32'h0000_0000},
        '{1'b0, 2'd1, 16'h0000, 1'b1, 32'h0000_0FFF},
        '{1'b0, 2'd1, 16'h0FFF, 1'b1, 32'h0FFF_0000},
        '{1'b1, 2'd1, 16'h0000, 1'b1, 32'h0000_0FFF},
        '{1'b1, 2'd1, 16'h0FFF, 1'b1, 32'h0FFF_0000},
        '{1'b0, 2'd1, 16'h06A5, 1'b1, 32'h052B_0AD4},
        '{1'b1, 2'd1, 16'h06A5, 1'b1, 32'h052B_0AD4},
        '{1'b0, 2'd2, 16'h005A, 1'b0, 32'h0},
        '{1'b1, 2'd2, 16'h005A, 1'b0, 32'h0},
        '{1'b1, 2'd2, 16'h00C3, 1'b0, 32'h0}
    };

    logic        clk;
    logic        rst;
    logic        arm;
    logic        halt;
    logic        bus16;
    logic        din_vld;
    logic [15:0] din;
    logic [31:0] result;
    logic        done;

    int checks;
    int failures;

    nand_hecc_gen dut_i (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .halt    (halt),
        .bus16   (bus16),
        .din_vld (din_vld),
        .din     (din),
        .result  (result),
        .done    (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [1:0] kind, input logic [15:0] param,
                                       input int a);
        logic [8:0] ad;
        ad = 9'(a);
        case (kind)
            2'd0:    return param[7:0];
            2'd1:    return (ad == param[8:0]) ? (8'h01 << param[11:9]) : 8'h00;
            default: return (ad[7:0] * 8'd37) ^ {7'b0, ad[8]} ^ param[7:0];
        endcase
    endfunction

    // Reference from the parity definition: per position bit, XOR over the
    // data bits whose position bit is 1 (odd) or 0 (even).
    function automatic logic [31:0] model(input logic [1:0] kind, input logic [15:0] param,
                                          input int nbytes);
        logic [11:0] odd;
        logic [11:0] even;
        logic [11:0] pos;
        logic [7:0]  b;
        odd  = '0;
        even = '0;
        for (int a = 0; a < nbytes; a++) begin
            b = pat(kind, param, a);
            for (int i = 0; i < 8; i++) begin
                pos = {9'(a), 3'(i)};
                for (int k = 0; k < 12; k++) begin
                    if (b[i]) begin
                        if (pos[k]) odd[k]  = ~odd[k];
                        else        even[k] = ~even[k];
                    end
                end
            end
        end
        return {4'b0, odd, 4'b0, even};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_arm(input logic w16);
        arm   = 1'b1;
        bus16 = w16;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic beat(input logic [15:0] d);
        din_vld = 1'b1;
        din     = d;
        @(negedge clk);
        din_vld = 1'b0;
    endtask

    task automatic send_bytes(input logic w16, input logic [1:0] kind, input logic [15:0] param,
                              input int from, input int upto, input logic [7:0] hi_fill);
        if (!w16) begin
            for (int a = from; a < upto; a++) beat({hi_fill, pat(kind, param, a)});
        end else begin
            for (int a = from; a < upto; a += 2)
                beat({pat(kind, param, a + 1), pat(kind, param, a)});
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks = 0; failures = 0;
        rst = 1'b1; arm = 1'b0; halt = 1'b0; bus16 = 1'b0; din_vld = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and beats before the first arm
        check("R1 reset result", result, 32'h0);
        check("R1 reset done", {31'b0, done}, 32'h0);
        beat(16'h0001);
        beat(16'h8040);
        check("R1 beats before arm ignored", result, 32'h0);

        // Vector table: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] exp;
            pulse_arm(VECS[v].w16);
            send_bytes(VECS[v].w16, VECS[v].kind, VECS[v].param, 0, 512, 8'hA5);
            exp = VECS[v].use_lit ? VECS[v].lit : model(VECS[v].kind, VECS[v].param, 512);
            check(VECS[v].w16 ? "R6 R3 R4 16-bit chunk code" : "R5 R3 R4 8-bit chunk code",
                  result, exp);
            check("R7 done after chunk", {31'b0, done}, 32'h1);
        end

        // R7: done rises exactly after the 512th byte; later beats ignored
        pulse_arm(1'b0);
        send_bytes(1'b0, 2'd2, 16'h0011, 0, 511, 8'h00);
        check("R7 done low at 511 bytes", {31'b0, done}, 32'h0);
        check("R10 partial code at 511", result, model(2'd2, 16'h0011, 511));
        send_bytes(1'b0, 2'd2, 16'h0011, 511, 512, 8'h00);
        check("R7 done high at 512 bytes", {31'b0, done}, 32'h1);
        beat(16'h00FE);
        beat(16'h0001);
        check("R7 beats after done ignored", result, model(2'd2, 16'h0011, 512));
        check("R7 done held", {31'b0, done}, 32'h1);

        // R10: one beat shows one cycle later
        pulse_arm(1'b0);
        beat(16'h0001);
        check("R10 code after first beat", result, 32'h0000_0FFF);

        // R8: halt mid-chunk keeps the partial code
        pulse_arm(1'b1);
        send_bytes(1'b1, 2'd2, 16'h0033, 0, 100, 8'h00);
        halt = 1'b1; din_vld = 1'b1; din = 16'hFFFF;
        @(negedge clk);
        halt = 1'b0; din_vld = 1'b0;
        send_bytes(1'b1, 2'd2, 16'h0077, 100, 140, 8'h00);
        check("R8 halt freezes partial code", result, model(2'd2, 16'h0033, 100));
        check("R8 no done after halt", {31'b0, done}, 32'h0);

        // R2: arm clears; beat in the arm cycle is not counted
        arm = 1'b1; bus16 = 1'b0; din_vld = 1'b1; din = 16'h0001;
        @(negedge clk);
        arm = 1'b0; din_vld = 1'b0;
        check("R2 arm clears code", result, 32'h0);
        check("R2 arm clears done", {31'b0, done}, 32'h0);
        send_bytes(1'b0, 2'd1, 16'h0FFF, 0, 512, 8'h00);
        check("R2 arm-cycle beat not counted", result, 32'h0FFF_0000);

        // R2: arm wins over halt
        arm = 1'b1; halt = 1'b1; bus16 = 1'b0;
        @(negedge clk);
        arm = 1'b0; halt = 1'b0;
        beat(16'h0001);
        check("R2 arm beats halt", result, 32'h0000_0FFF);

        // R9: width captured at arm; bus16 toggled mid-chunk
        pulse_arm(1'b0);
        bus16 = 1'b1;
        send_bytes(1'b0, 2'd2, 16'h0099, 0, 256, 8'hFF);
        check("R9 no early done", {31'b0, done}, 32'h0);
        send_bytes(1'b0, 2'd2, 16'h0099, 256, 512, 8'hFF);
        check("R9 width held at arm", result, model(2'd2, 16'h0099, 512));
        check("R9 done after 512 beats", {31'b0, done}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule